// File: doc/BRIEF.md
# Mailbox Channel Request Dispatcher

The dispatcher accepts 32-bit host writes aimed at an outbound mailbox window. It sends each message to one of a set of peripheral channels. The target channel is carried inside the message: its four least significant bits select it. When the selected channel is idle, the word is handed to it directly as a one-cycle valid strobe on a shared data bus.

When the selected channel reports busy, the word is instead stored in a small outbound queue. The queue later drains in arrival order, one word per cycle, whenever its head's channel is idle. Messages are dropped in two cases: when the queue is already full, and when the channel field names a channel that does not exist. Each kind of drop raises its own one-cycle flag.

A read port returns a status word for the queue. Host software uses it to see whether the queue is full or empty before it posts more work.

Top module: `mbox_dispatch`

## Requirements
- R1: A write is a mailbox message only when the upper nibble of its 8-bit offset is 0xA, which covers offsets 0xA0, 0xA4, 0xA8 and 0xAC. A write at any other offset changes no output, no flag and no queue state.
- R2: The target channel is data bits [3:0]. If that channel's busy input is low when the write is taken, the cycle after the write `chan_valid` carries exactly that channel's bit for one cycle, and `chan_data` carries the full 32-bit word.
- R3: A channel field at or above NUM_CHAN discards the message and raises `bad_chan` for one cycle after the write. Nothing is queued and nothing is delivered.
- R4: If the target channel's busy input is high, the word is appended to the outbound queue and is not delivered in that cycle.
- R5: If the queue holds QUEUE_DEPTH words when a message is written, the message is discarded and `queue_ovf` pulses the next cycle. This check comes before the channel decode, so it applies even to idle or invalid channels, and `bad_chan` stays low.
- R6: A read at offset 0xB8 returns the status word: bit 31 set when the queue is full, bit 30 set when it is empty, and every other bit zero. A read at any other offset returns zero.
- R7: The queue drains in FIFO order. The head word is delivered on `chan_valid`/`chan_data` the cycle after a cycle in which its channel is idle and no direct delivery is taken. At most one word leaves per cycle.
- R8: While the head's channel is busy, no queued word is delivered, even if the channels of later entries are idle.
- R9: After reset the queue is empty (status 0x4000_0000), `chan_valid` is zero, and both drop flags are low.
- R10: At most one bit of `chan_valid` is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 8 | Host write byte offset |
| wr_data | input | 32 | Host write word; bits [3:0] select the channel |
| rd_addr | input | 8 | Host read byte offset |
| rd_data | output | 32 | Read data: queue status at 0xB8, zero elsewhere |
| chan_busy | input | NUM_CHAN | Per-channel busy indication |
| chan_valid | output | NUM_CHAN | Per-channel one-cycle delivery strobe |
| chan_data | output | 32 | Word delivered with the strobe |
| queue_ovf | output | 1 | Pulse: message dropped because the queue was full |
| bad_chan | output | 1 | Pulse: message dropped because of an invalid channel |

## Verification
A corrupted queue pointer or count shows up within one read of offset 0xB8 as a wrong full or empty bit. It also appears during the drain as a word delivered out of order or to the wrong channel strobe. A wrong decode is visible one cycle after the offending write, as a strobe on the wrong channel, a missing strobe, or a drop flag of the wrong kind. The bench therefore sweeps every 4-bit channel code, both idle and busy, and fills the queue to its limit. It then drains the queue, checking each delivered word in the cycle it is due.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int          DATA_W    = 32;
    localparam int          CH_FIELD  = 4;
    localparam logic [3:0]  WIN_NIB   = 4'hA;
    localparam logic [7:0]  STAT_OFS  = 8'hB8;
    localparam int          FULL_BIT  = 31;
    localparam int          EMPTY_BIT = 30;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_DIRECT,
        ACT_QUEUE,
        ACT_DROP_FULL,
        ACT_DROP_BAD
    } act_e;
endpackage

// File: rtl/mbox_queue.sv
module mbox_queue #(
    parameter int DEPTH = 8,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } qstate_t;

    qstate_t      st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign rdata = mem_q[st_q.rd];

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        if (pop)  st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wr] <= wdata;
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/mbox_route.sv
module mbox_route
    import mbox_pkg::*;
#(
    parameter int NUM_CHAN = 9
) (
    input  logic                wr_en,
    input  logic [7:0]          wr_addr,
    input  logic [CH_FIELD-1:0] ch,
    input  logic [NUM_CHAN-1:0] chan_busy,
    input  logic                q_full,
    output act_e                act
);
    logic in_window;
    logic ch_ok;
    logic ch_busy;

    assign in_window = wr_en && (wr_addr[7:4] == WIN_NIB);
    assign ch_ok     = (32'(ch) < NUM_CHAN);

    always_comb begin
        ch_busy = 1'b0;
        for (int c = 0; c < NUM_CHAN; c++)
            if (ch == CH_FIELD'(c)) ch_busy = chan_busy[c];
    end

    // full is judged before the channel field (R5)
    always_comb begin
        act = ACT_NONE;
        if (in_window) begin
            if (q_full)       act = ACT_DROP_FULL;
            else if (!ch_ok)  act = ACT_DROP_BAD;
            else if (ch_busy) act = ACT_QUEUE;
            else              act = ACT_DIRECT;
        end
    end
endmodule

// File: rtl/mbox_dispatch.sv
module mbox_dispatch
    import mbox_pkg::*;
#(
    parameter int NUM_CHAN    = 9,
    parameter int QUEUE_DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [7:0]          wr_addr,
    input  logic [31:0]         wr_data,
    input  logic [7:0]          rd_addr,
    output logic [31:0]         rd_data,
    input  logic [NUM_CHAN-1:0] chan_busy,
    output logic [NUM_CHAN-1:0] chan_valid,
    output logic [31:0]         chan_data,
    output logic                queue_ovf,
    output logic                bad_chan
);
    typedef struct packed {
        logic [NUM_CHAN-1:0] valid;
        logic [DATA_W-1:0]   data;
        logic                ovf;
        logic                bad;
    } ost_t;

    ost_t        st_d, st_q;
    act_e        act;
    logic        q_full, q_empty, q_push, q_pop, head_busy;
    logic [31:0] head;

    mbox_route #(.NUM_CHAN(NUM_CHAN)) u_route (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .ch        (wr_data[CH_FIELD-1:0]),
        .chan_busy (chan_busy),
        .q_full    (q_full),
        .act       (act)
    );

    mbox_queue #(.DEPTH(QUEUE_DEPTH), .W(DATA_W)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .pop   (q_pop),
        .wdata (wr_data),
        .rdata (head),
        .full  (q_full),
        .empty (q_empty)
    );

    always_comb begin
        head_busy = 1'b0;
        for (int c = 0; c < NUM_CHAN; c++)
            if (head[CH_FIELD-1:0] == CH_FIELD'(c)) head_busy = chan_busy[c];
    end

    assign q_push = (act == ACT_QUEUE);
    assign q_pop  = (act != ACT_DIRECT) && !q_empty && !head_busy;

    always_comb begin
        st_d       = st_q;
        st_d.valid = '0;
        st_d.ovf   = (act == ACT_DROP_FULL);
        st_d.bad   = (act == ACT_DROP_BAD);
        if (act == ACT_DIRECT) begin
            for (int c = 0; c < NUM_CHAN; c++)
                st_d.valid[c] = (wr_data[CH_FIELD-1:0] == CH_FIELD'(c));
            st_d.data = wr_data;
        end else if (q_pop) begin
            for (int c = 0; c < NUM_CHAN; c++)
                st_d.valid[c] = (head[CH_FIELD-1:0] == CH_FIELD'(c));
            st_d.data = head;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chan_valid = st_q.valid;
    assign chan_data  = st_q.data;
    assign queue_ovf  = st_q.ovf;
    assign bad_chan   = st_q.bad;

    always_comb begin
        rd_data = '0;
        if (rd_addr == STAT_OFS) begin
            rd_data[FULL_BIT]  = q_full;
            rd_data[EMPTY_BIT] = q_empty;
        end
    end

    assert_onehot_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_valid));
    assert_ovf_after_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[7:4] == WIN_NIB && q_full) |=> (queue_ovf && !bad_chan));
    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(queue_ovf && bad_chan));

    generate
        for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chk
            assert_idle_delivery_R2: assert property (@(posedge clk) disable iff (!rst_n)
                chan_valid[g] |-> !$past(chan_busy[g]));
        end
    endgenerate
endmodule

// File: tb/mbox_dispatch_test.sv
module mbox_dispatch_test;
    localparam int NCH = 9;
    localparam int QD  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [7:0]      wr_addr = '0;
    logic [31:0]     wr_data = '0;
    logic [7:0]      rd_addr = 8'hB8;
    logic [31:0]     rd_data;
    logic [NCH-1:0]  chan_busy = '0;
    logic [NCH-1:0]  chan_valid;
    logic [31:0]     chan_data;
    logic            queue_ovf, bad_chan;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mbox_dispatch #(.NUM_CHAN(NCH), .QUEUE_DEPTH(QD)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .chan_busy(chan_busy), .chan_valid(chan_valid), .chan_data(chan_data),
        .queue_ovf(queue_ovf), .bad_chan(bad_chan)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // one-cycle write; returns at the negedge after the capturing edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] qword(input int i);
        return 32'hA500_0000 | 32'(i << 8) | 32'(i);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(rd_data == 32'h4000_0000, "R9 status", rd_data, 32'h4000_0000);
        check(chan_valid == '0, "R9 valid", 32'(chan_valid), 0);
        check(!queue_ovf && !bad_chan, "R9 flags", {queue_ovf, bad_chan}, 0);

        // R2/R3 sweep every channel code across the whole window (R1)
        for (int c = 0; c < 16; c++) begin
            logic [31:0] d;
            d = 32'h1234_5600 | 32'(c);
            wr(8'hA0 + 8'(4 * (c % 4)), d);
            if (c < NCH) begin
                check(chan_valid == NCH'(1 << c), "R2 strobe", 32'(chan_valid), 32'(1 << c));
                check(chan_data == d, "R2 data", chan_data, d);
                check(!bad_chan, "R2 no bad flag", 32'(bad_chan), 0);
            end else begin
                check(chan_valid == '0, "R3 no strobe", 32'(chan_valid), 0);
                check(bad_chan, "R3 bad flag", 32'(bad_chan), 1);
            end
            @(negedge clk);
            check(chan_valid == '0 && !bad_chan, "R2 R3 single cycle", {chan_valid, bad_chan}, 0);
        end
        check(rd_data == 32'h4000_0000, "R3 nothing queued", rd_data, 32'h4000_0000);

        // R1 write outside the window
        wr(8'h90, 32'h0000_0002);
        check(chan_valid == '0 && !queue_ovf && !bad_chan, "R1 ignored offset", {chan_valid, queue_ovf, bad_chan}, 0);
        check(rd_data == 32'h4000_0000, "R1 queue untouched", rd_data, 32'h4000_0000);

        // R6 other read offset
        rd_addr = 8'h98; #1;
        check(rd_data == 0, "R6 other offset", rd_data, 0);
        rd_addr = 8'hB8;

        // R4 fill the queue with every channel busy
        chan_busy = '1;
        for (int i = 0; i < QD; i++) begin
            wr(8'hA4, qword(i));
            check(chan_valid == '0, "R4 no delivery", 32'(chan_valid), 0);
            if (i < QD - 1)
                check(rd_data == 0, "R6 partial", rd_data, 0);
        end
        check(rd_data == 32'h8000_0000, "R6 full", rd_data, 32'h8000_0000);

        // R5 full drops, even for an idle channel and for an invalid channel
        chan_busy = 9'h0FF;
        wr(8'hA8, 32'hDEAD_0008);
        check(queue_ovf && chan_valid == '0, "R5 idle dropped", {queue_ovf, chan_valid}, 32'h200);
        wr(8'hAC, 32'hDEAD_000C);
        check(queue_ovf && !bad_chan, "R5 full before decode", {queue_ovf, bad_chan}, 2);

        // R8 head busy blocks later idle channels
        chan_busy = 9'h0FD;
        repeat (2) @(negedge clk);
        check(chan_valid == '0, "R8 head of line", 32'(chan_valid), 0);
        check(rd_data == 32'h8000_0000, "R8 still full", rd_data, 32'h8000_0000);

        // R7 drain in order, one per cycle
        chan_busy = '0;
        for (int i = 0; i < QD; i++) begin
            @(negedge clk);
            check(chan_valid == NCH'(1 << i), "R7 drain strobe", 32'(chan_valid), 32'(1 << i));
            check(chan_data == qword(i), "R7 drain order", chan_data, qword(i));
        end
        @(negedge clk);
        check(chan_valid == '0, "R7 drained", 32'(chan_valid), 0);
        check(rd_data == 32'h4000_0000, "R7 empty", rd_data, 32'h4000_0000);

        finish_run();
    end
endmodule